// File: doc/BRIEF.md
# Sampling Converter Control Front-End

This block is the clocked digital side of a 12-bit sampling converter. It watches an active-low chip select and a read/convert line, starts a conversion when both are low, holds a busy indication low for a fixed number of clock cycles, and then loads the new result into an output register. The analog sampling, reference and bit search are not modelled. A test input supplies the 12-bit two's-complement value that is captured when each conversion finishes.

The result is presented on a 16-pin parallel port, modelled as a data vector plus a per-pin output-enable vector. A byte-select input chooses which 8-bit half of the word appears on the upper and lower pin groups. While a conversion runs, the previous result can still be read, but only during an early window. A status flag tells whether the word currently presented is trustworthy.

Top module: `sfe_frontend`

## Requirements
- R1: A conversion starts on the first rising clock edge at which `cs_n` and `rdconv` are both sampled low while `ready_o` is high, and `ready_o` is low after that edge.
- R2: `ready_o` stays low for exactly `CONV_CYCLES` clock cycles. At the edge where it returns high, the output register takes the value on `result_in` from that edge.
- R3: While `ready_o` is low, any activity on `cs_n` and `rdconv` is ignored. The conversion length and the captured value are unchanged.
- R4: If `cs_n` and `rdconv` are both still low at the edge that ends a conversion, a new conversion starts one cycle later. When that new conversion completes, `data_valid_o` is low.
- R5: `data_oe_o` is all ones only when `cs_n` is low and `rdconv` is high. In every other case it is all zeros and `data_o` is zero.
- R6: During a conversion, the previous result stays on the port. `data_valid_o` keeps its previous value for the first `PREV_WIN_CYCLES` cycles after the start. After that it is low until `ready_o` rises.
- R7: Results are passed through as 12-bit two's complement. The codes 0x7FF, 0x000, 0xFFF and 0x800 each appear unchanged.
- R8: With `byte_sel` low, `data_o[15:8]` holds result bits 11 to 4 and `data_o[7:0]` holds result bits 3 to 0 followed by four zero bits.
- R9: With `byte_sel` high, the two halves are swapped. `data_o[15:8]` holds result bits 3 to 0 followed by four zero bits, and `data_o[7:0]` holds result bits 11 to 4.
- R10: After reset, `ready_o` is high, `data_oe_o` is zero and `data_valid_o` is low.
- R11: Because the two inputs are combined as a level, the start comes from whichever input falls last. This can be a falling `cs_n` while `rdconv` is low, or a falling `rdconv` while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rdconv | input | 1 | Low requests a conversion, high requests a read |
| byte_sel | input | 1 | Swaps the two 8-bit halves of the port |
| result_in | input | 12 | Test value captured at the end of each conversion |
| ready_o | output | 1 | Low while a conversion is running |
| data_o | output | 16 | Parallel port data (zero when not driven) |
| data_oe_o | output | 16 | Per-pin drive enable; zero means high impedance |
| data_valid_o | output | 1 | High when the presented result is trustworthy |

## Verification
Inputs change at the falling clock edge and are sampled at the next rising edge. `ready_o` is therefore low one half cycle after the stimulus. It is high again after `CONV_CYCLES + 1` falling edges, so the bench checks it low at falling edge `CONV_CYCLES` and high at edge `CONV_CYCLES + 1`. The previous-result window is checked at falling edge `PREV_WIN_CYCLES`, where the flag is still valid, and at edge `PREV_WIN_CYCLES + 1`, where it is not. The port mapping and output enables are combinational, so they are checked in the same half cycle as the input change. Each directed task counts falling edges from its own stimulus and samples only at those computed edges.

// File: rtl/sfe_pkg.sv
// Package: shared widths for the converter front-end.
// Assumes a 12-bit result presented on a 16-pin port split in two 8-bit halves.
package sfe_pkg;
    localparam int RES_W  = 12;
    localparam int PORT_W = 16;
    localparam int HALF_W = PORT_W / 2;
    localparam int PAD_W  = 2 * HALF_W - RES_W;

    typedef logic [RES_W-1:0]  result_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [PORT_W-1:0] port_t;
endpackage

// File: rtl/sfe_start_ctl.sv
// Start decoder: combines chip select and read/convert as a level request.
// Assumes both inputs are synchronous to clk. Flags a start that follows the
// completion edge with the request still held, since no acquisition happened.
module sfe_start_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rdconv,
    input  logic idle,
    input  logic done,
    output logic start,
    output logic start_noacq
);
    logic req;
    logic held_q;

    // Level request: both lines low
    always_comb req = ~cs_n & ~rdconv;

    // Start only when idle; tag starts that follow a held completion
    always_comb begin
        start       = idle & req;
        start_noacq = idle & req & held_q;
    end

    // Remember whether the request was still present at the completion edge
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= done & req;
    end
endmodule

// File: rtl/sfe_conv_timer.sv
// Conversion timer: runs a counter for CONV_CYCLES cycles after each start.
// Assumes PREV_WIN_CYCLES < CONV_CYCLES. Starts arriving while busy are
// ignored because the start decoder only fires when idle.
module sfe_conv_timer #(
    parameter int CONV_CYCLES     = 440,
    parameter int PREV_WIN_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_noacq,
    output logic busy,
    output logic done,
    output logic in_window,
    output logic noacq
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] WIN  = CNT_W'(PREV_WIN_CYCLES);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             noacq_q;

    // Decode completion and the previous-data window from the count
    always_comb begin
        busy      = busy_q;
        done      = busy_q & (cnt_q == LAST);
        in_window = busy_q & (cnt_q < WIN);
        noacq     = noacq_q;
    end

    // Busy flag and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Carry the no-acquisition tag through the running conversion
    always_ff @(posedge clk) begin
        if (!rst_n)     noacq_q <= 1'b0;
        else if (start) noacq_q <= start_noacq;
    end
endmodule

// File: rtl/sfe_result_reg.sv
// Output register: captures the test result at completion and keeps a trust
// bit. Assumes done is a single-cycle pulse from the timer.
module sfe_result_reg
    import sfe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    done,
    input  logic    noacq,
    input  result_t result_in,
    output result_t data_q,
    output logic    ok_q
);
    // Load result and its trust bit at the end of a conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ok_q   <= 1'b0;
        end else if (done) begin
            data_q <= result_in;
            ok_q   <= ~noacq;
        end
    end
endmodule

// File: rtl/sfe_port_mux.sv
// Port mux: splits the result into two 8-bit halves, orders them by byte
// select and gates data and enables by the read condition.
// Assumes the low half is padded with zeros below the four low result bits.
module sfe_port_mux
    import sfe_pkg::*;
(
    input  result_t word,
    input  logic    cs_n,
    input  logic    rdconv,
    input  logic    byte_sel,
    output port_t   data_o,
    output port_t   data_oe_o
);
    half_t hi_half;
    half_t lo_half;
    port_t ordered;
    logic  drive;

    // Build the two halves of the result
    always_comb begin
        hi_half = word[RES_W-1 -: HALF_W];
        lo_half = {word[RES_W-HALF_W-1:0], {PAD_W{1'b0}}};
    end

    // Order the halves by byte select
    always_comb ordered = byte_sel ? {lo_half, hi_half} : {hi_half, lo_half};

    // Drive only when selected in read mode
    always_comb begin
        drive     = ~cs_n & rdconv;
        data_oe_o = {PORT_W{drive}};
        data_o    = drive ? ordered : '0;
    end
endmodule

// File: rtl/sfe_frontend.sv
// Top: converter control front-end. Connects start decode, conversion timer,
// output register and port mux. Assumes cs_n, rdconv and byte_sel are
// synchronous to clk; result_in stands in for the analog search result.
module sfe_frontend
    import sfe_pkg::*;
#(
    parameter int CONV_CYCLES     = 440,
    parameter int PREV_WIN_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rdconv,
    input  logic              byte_sel,
    input  logic [RES_W-1:0]  result_in,
    output logic              ready_o,
    output logic [PORT_W-1:0] data_o,
    output logic [PORT_W-1:0] data_oe_o,
    output logic              data_valid_o
);
    logic    start, start_noacq;
    logic    busy, done, in_window, noacq;
    result_t stored;
    logic    stored_ok;

    sfe_start_ctl u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rdconv      (rdconv),
        .idle        (~busy),
        .done        (done),
        .start       (start),
        .start_noacq (start_noacq)
    );

    sfe_conv_timer #(
        .CONV_CYCLES     (CONV_CYCLES),
        .PREV_WIN_CYCLES (PREV_WIN_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_noacq (start_noacq),
        .busy        (busy),
        .done        (done),
        .in_window   (in_window),
        .noacq       (noacq)
    );

    sfe_result_reg u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .noacq     (noacq),
        .result_in (result_in),
        .data_q    (stored),
        .ok_q      (stored_ok)
    );

    sfe_port_mux u_mux (
        .word      (stored),
        .cs_n      (cs_n),
        .rdconv    (rdconv),
        .byte_sel  (byte_sel),
        .data_o    (data_o),
        .data_oe_o (data_oe_o)
    );

    // Busy indication and trust flag, closed after the window
    always_comb begin
        ready_o      = ~busy;
        data_valid_o = busy ? (stored_ok & in_window) : stored_ok;
    end
endmodule

// File: rtl/sfe_frontend_chk.sv
// Checker: temporal properties of the front-end, attached by bind.
// Keeps its own count of cycles spent with ready low.
module sfe_frontend_chk #(
    parameter int CONV_CYCLES     = 440,
    parameter int PREV_WIN_CYCLES = 300
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        rdconv,
    input logic        byte_sel,
    input logic [11:0] result_in,
    input logic        ready_o,
    input logic [15:0] data_o,
    input logic [15:0] data_oe_o,
    input logic        data_valid_o,
    input logic [11:0] stored
);
    localparam int LW = $clog2(CONV_CYCLES + 1) + 1;
    logic [LW-1:0] low_cnt;

    // Count cycles with ready low
    always_ff @(posedge clk) begin
        if (!rst_n || ready_o) low_cnt <= '0;
        else                   low_cnt <= low_cnt + 1'b1;
    end

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (low_cnt == LW'(CONV_CYCLES)));                  // R2
    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (stored == $past(result_in)));                   // R2
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (low_cnt < LW'(CONV_CYCLES)));                         // R3
    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !cs_n && !rdconv) |=> !ready_o);                         // R1
    AST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && low_cnt >= LW'(PREV_WIN_CYCLES)) |-> !data_valid_o);   // R6
    AST_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !rdconv) |-> (data_oe_o == 16'h0 && data_o == 16'h0));     // R5
    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(data_oe_o) == 0 || $countones(data_oe_o) == 16);         // R5
    AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o[0] && !byte_sel) |-> (data_o[3:0] == 4'h0));             // R8
    AST_PAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o[0] && byte_sel) |-> (data_o[11:8] == 4'h0));             // R9
    AST_PREV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && $past(!ready_o)) |-> $stable(stored));                  // R6
endmodule

bind sfe_frontend sfe_frontend_chk #(
    .CONV_CYCLES     (CONV_CYCLES),
    .PREV_WIN_CYCLES (PREV_WIN_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .rdconv       (rdconv),
    .byte_sel     (byte_sel),
    .result_in    (result_in),
    .ready_o      (ready_o),
    .data_o       (data_o),
    .data_oe_o    (data_oe_o),
    .data_valid_o (data_valid_o),
    .stored       (stored)
);

// File: tb/sfe_frontend_tb.sv
`timescale 1ns/1ps
module sfe_frontend_tb;
    localparam int CONV = 440;
    localparam int WIN  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rdconv = 1'b1;
    logic        byte_sel = 1'b0;
    logic [11:0] result_in = '0;
    logic        ready_o;
    logic [15:0] data_o;
    logic [15:0] data_oe_o;
    logic        data_valid_o;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    sfe_frontend #(.CONV_CYCLES(CONV), .PREV_WIN_CYCLES(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdconv(rdconv),
        .byte_sel(byte_sel), .result_in(result_in), .ready_o(ready_o),
        .data_o(data_o), .data_oe_o(data_oe_o), .data_valid_o(data_valid_o)
    );

    function automatic logic [15:0] port_of(logic [11:0] r, logic bs);
        logic [7:0] hi = r[11:4];
        logic [7:0] lo = {r[3:0], 4'h0};
        return bs ? {lo, hi} : {hi, lo};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Start via rdconv falling with cs low, release to read mode, check length
    task automatic convert(logic [11:0] v);
        result_in = v;
        cs_n = 1'b0; rdconv = 1'b0;
        step(1);
        chk(ready_o == 1'b0, "R1 ready low after start", ready_o, 0);
        rdconv = 1'b1;
        step(CONV - 1);
        chk(ready_o == 1'b0, "R2 ready low at last cycle", ready_o, 0);
        step(1);
        chk(ready_o == 1'b1, "R2 ready high after length", ready_o, 1);
    endtask

    task automatic t_reset();
        chk(ready_o == 1'b1, "R10 ready", ready_o, 1);
        chk(data_oe_o == 16'h0, "R10 oe", data_oe_o, 0);
        chk(data_valid_o == 1'b0, "R10 valid", data_valid_o, 0);
    endtask

    task automatic t_codes();
        logic [11:0] vals [4] = '{12'h7FF, 12'h000, 12'hFFF, 12'h800};
        foreach (vals[i]) begin
            convert(vals[i]);
            byte_sel = 1'b0;
            #1;
            chk(data_o == port_of(vals[i], 1'b0), "R7 R8 code low order", data_o, port_of(vals[i], 1'b0));
            chk(data_valid_o == 1'b1, "R2 valid after load", data_valid_o, 1);
            byte_sel = 1'b1;
            #1;
            chk(data_o == port_of(vals[i], 1'b1), "R9 swapped order", data_o, port_of(vals[i], 1'b1));
            byte_sel = 1'b0;
            step(1);
        end
    endtask

    task automatic t_hiz();
        cs_n = 1'b1; rdconv = 1'b1;
        step(1);
        chk(data_oe_o == 16'h0 && data_o == 16'h0, "R5 cs high", data_oe_o, 0);
        rdconv = 1'b0;
        step(1);
        chk(data_oe_o == 16'h0, "R5 cs high rdconv low", data_oe_o, 0);
        chk(ready_o == 1'b1, "R11 no start with cs high", ready_o, 1);
        cs_n = 1'b0; rdconv = 1'b1;
        #1;
        chk(data_oe_o == 16'hFFFF, "R5 read mode drives", data_oe_o, 16'hFFFF);
        step(1);
    endtask

    // cs_n falls last while rdconv is already low
    task automatic t_cs_start();
        cs_n = 1'b1; rdconv = 1'b0; result_in = 12'h5A3;
        step(2);
        chk(ready_o == 1'b1, "R11 idle before cs falls", ready_o, 1);
        cs_n = 1'b0;
        step(1);
        chk(ready_o == 1'b0, "R11 cs_n falling starts", ready_o, 0);
        chk(data_oe_o == 16'h0, "R5 convert mode high-z", data_oe_o, 0);
        cs_n = 1'b1; rdconv = 1'b1;
        step(CONV);
        chk(ready_o == 1'b1, "R2 ready after cs start", ready_o, 1);
        cs_n = 1'b0;
        #1;
        chk(data_o == port_of(12'h5A3, 1'b0), "R11 result loaded", data_o, port_of(12'h5A3, 1'b0));
        step(1);
    endtask

    // Repeated start requests during a conversion are ignored
    task automatic t_ignore();
        convert(12'h123);
        result_in = 12'h3C5;
        cs_n = 1'b0; rdconv = 1'b0;
        step(1);
        rdconv = 1'b1;
        step(40);
        for (int k = 0; k < 5; k++) begin
            rdconv = 1'b0; step(2);
            rdconv = 1'b1; step(2);
            cs_n = 1'b1;   step(1);
            cs_n = 1'b0;   step(1);
        end
        step(CONV - 1 - 40 - 30);
        chk(ready_o == 1'b0, "R3 still busy", ready_o, 0);
        result_in = 12'h6E1;
        step(1);
        chk(ready_o == 1'b1, "R3 length unchanged", ready_o, 1);
        #1;
        chk(data_o == port_of(12'h6E1, 1'b0), "R3 value at completion", data_o, port_of(12'h6E1, 1'b0));
        step(1);
        chk(ready_o == 1'b1, "R3 no late restart", ready_o, 1);
    endtask

    // Previous result readable only inside the window
    task automatic t_window();
        convert(12'h2B7);
        result_in = 12'h444;
        cs_n = 1'b0; rdconv = 1'b0;
        step(1);
        rdconv = 1'b1;
        step(WIN - 1);
        chk(data_valid_o == 1'b1, "R6 valid inside window", data_valid_o, 1);
        chk(data_o == port_of(12'h2B7, 1'b0), "R6 previous data", data_o, port_of(12'h2B7, 1'b0));
        step(1);
        chk(data_valid_o == 1'b0, "R6 invalid after window", data_valid_o, 0);
        step(CONV - WIN - 1);
        chk(data_valid_o == 1'b0, "R6 invalid at last cycle", data_valid_o, 0);
        step(1);
        chk(data_valid_o == 1'b1, "R6 valid after completion", data_valid_o, 1);
        chk(data_o == port_of(12'h444, 1'b0), "R6 new data", data_o, port_of(12'h444, 1'b0));
    endtask

    // Request held through completion: immediate restart, result untrusted
    task automatic t_back();
        result_in = 12'h0F0;
        cs_n = 1'b0; rdconv = 1'b0;
        step(CONV);
        chk(ready_o == 1'b0, "R4 first busy", ready_o, 0);
        step(1);
        chk(ready_o == 1'b1, "R4 first done", ready_o, 1);
        step(1);
        chk(ready_o == 1'b0, "R4 restarted next cycle", ready_o, 0);
        result_in = 12'h0AB;
        rdconv = 1'b1;
        step(CONV - 1);
        chk(ready_o == 1'b0, "R4 second busy", ready_o, 0);
        step(1);
        chk(ready_o == 1'b1, "R4 second done", ready_o, 1);
        chk(data_valid_o == 1'b0, "R4 second flagged invalid", data_valid_o, 0);
        chk(data_o == port_of(12'h0AB, 1'b0), "R4 second data", data_o, port_of(12'h0AB, 1'b0));
        convert(12'h777);
        chk(data_valid_o == 1'b1, "R4 normal conversion valid again", data_valid_o, 1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_codes();
        t_hiz();
        t_cs_start();
        t_ignore();
        t_window();
        t_back();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule